// File: doc/BRIEF.md
# Display Window Write Sequencer

This block turns a dirty rectangle, given in pixel coordinates, into the byte sequence a panel controller needs to update that region of its frame memory. The panel stores three pixels in each memory byte. The block therefore widens the horizontal span outward to whole three-pixel columns. It then works out the packed column range, the row range and the number of data bytes.

It first emits a column-range command and a row-range command, each followed by four address parameters. Then it emits a memory-write command. After that it forwards exactly the computed number of packed pixel bytes from an upstream pixel-byte source, using a valid/ready handshake.

Each output byte comes with a select line that tells commands apart from parameters and data. A one-cycle done pulse marks the end of the transfer. Pixel packing and serial shifting are handled elsewhere.

Top module: `wws_top`

## Requirements
- R1: Out of reset, and whenever no transfer is running, `busy_o`, `out_valid_o`, `px_ready_o` and `done_o` are low.
- R2: The packed column start is floor(x1/3) and the packed column end is ceil(x2/3). After command byte 0x2A the block sends four parameter bytes in this order: start bits 15:8, start bits 7:0, end bits 15:8, and bits 7:0 of (end - 1).
- R3: After command byte 0x2B the block sends four parameter bytes in this order: y1 bits 15:8, y1 bits 7:0, y2 bits 15:8, and bits 7:0 of (y2 - 1).
- R4: A transfer is 0x2A, its 4 parameters, 0x2B, its 4 parameters, 0x2C, then the data bytes. `out_dc_o` is 0 on the three command bytes and 1 on every parameter and data byte.
- R5: After 0x2C exactly (end - start) * (y2 - y1) data bytes follow. They are the pixel-source bytes, unchanged and in order. `px_ready_o` is high only in the data phase and only while `out_ready_i` is high.
- R6: While a command byte is offered and `out_ready_i` is low, the same byte stays offered on the next cycle.
- R7: `done_o` goes high for exactly one cycle. That cycle is the one right after the cycle in which the last data byte is accepted.
- R8: A rectangle with x2 <= x1 or y2 <= y1 is empty. It produces no bytes, `busy_o` stays low, and `done_o` pulses in the cycle after the request.
- R9: A request raised while `busy_o` is high is ignored. It does not change the bytes of the running transfer, and it does not start another transfer afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Rectangle request strobe, taken when idle |
| req_x1_i | input | COORD_W | Left pixel edge, inclusive |
| req_x2_i | input | COORD_W | Right pixel edge, exclusive |
| req_y1_i | input | COORD_W | Top row, inclusive |
| req_y2_i | input | COORD_W | Bottom row, exclusive |
| busy_o | output | 1 | Transfer in progress |
| px_valid_i | input | 1 | Pixel source has a packed byte |
| px_data_i | input | 8 | Packed pixel byte |
| px_ready_o | output | 1 | Pixel byte consumed this cycle |
| out_valid_o | output | 1 | Output byte offered |
| out_byte_o | output | 8 | Output byte |
| out_dc_o | output | 1 | 0 = command byte, 1 = parameter or data byte |
| out_ready_i | input | 1 | Downstream takes the offered byte |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The checker watches four things on every cycle: the idle outputs, how `px_ready_o` is tied to the data phase and to downstream ready, that a stalled command byte is held, and that done is a single-cycle pulse seen only when idle. The bench's scenarios cover the rest. These are the rounding of odd horizontal edges, the asymmetric end encoding (including a column end that crosses a byte boundary), the exact data-byte count under random-like stalls on both sides, the timing of done against the last accepted byte, empty rectangles, and requests raised while busy.

// File: rtl/wws_pkg.sv
package wws_pkg;
  localparam int ADDR_W  = 16;
  localparam int HDR_LEN = 11;

  localparam logic [7:0] CMD_COL = 8'h2A;
  localparam logic [7:0] CMD_ROW = 8'h2B;
  localparam logic [7:0] CMD_MEM = 8'h2C;

  typedef enum logic [1:0] {ST_IDLE, ST_HDR, ST_DATA} state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] col_s;
    logic [ADDR_W-1:0] col_e;
    logic [ADDR_W-1:0] row_s;
    logic [ADDR_W-1:0] row_e;
  } win_t;
endpackage

// File: rtl/wws_window.sv
module wws_window
  import wws_pkg::*;
#(
  parameter int COORD_W = 16,
  localparam int CNT_W = 2 * COORD_W + 1
) (
  input  logic [COORD_W-1:0] x1_i,
  input  logic [COORD_W-1:0] x2_i,
  input  logic [COORD_W-1:0] y1_i,
  input  logic [COORD_W-1:0] y2_i,
  output win_t               win_o,
  output logic               empty_o,
  output logic [CNT_W-1:0]   beats_o
);
  localparam logic [COORD_W-1:0] THREE_N = 3;
  localparam logic [COORD_W:0]   THREE_W = 3;

  logic [COORD_W-1:0] col_s;
  logic [COORD_W:0]   x2_up, col_e, span_x;
  logic [COORD_W-1:0] span_y;

  // floor on the left edge, ceil on the right edge
  assign x2_up  = {1'b0, x2_i} + THREE_W - 1'b1;
  assign col_s  = x1_i / THREE_N;
  assign col_e  = x2_up / THREE_W;
  assign span_x = col_e - {1'b0, col_s};
  assign span_y = y2_i - y1_i;

  assign empty_o = (x2_i <= x1_i) || (y2_i <= y1_i);
  assign beats_o = CNT_W'(span_x) * CNT_W'(span_y);

  assign win_o.col_s = ADDR_W'(col_s);
  assign win_o.col_e = ADDR_W'(col_e);
  assign win_o.row_s = ADDR_W'(y1_i);
  assign win_o.row_e = ADDR_W'(y2_i);
endmodule

// File: rtl/wws_header.sv
module wws_header
  import wws_pkg::*;
#(
  localparam int IDX_W = $clog2(HDR_LEN)
) (
  input  logic [IDX_W-1:0] idx_i,
  input  win_t             win_i,
  output logic [7:0]       byte_o,
  output logic             dc_o
);
  logic [ADDR_W-1:0] col_last, row_last;

  assign col_last = win_i.col_e - 1'b1;
  assign row_last = win_i.row_e - 1'b1;

  // end high byte is taken before the decrement, low byte after
  always_comb begin
    dc_o = 1'b1;
    case (int'(idx_i))
      0:  begin byte_o = CMD_COL; dc_o = 1'b0; end
      1:  byte_o = win_i.col_s[15:8];
      2:  byte_o = win_i.col_s[7:0];
      3:  byte_o = win_i.col_e[15:8];
      4:  byte_o = col_last[7:0];
      5:  begin byte_o = CMD_ROW; dc_o = 1'b0; end
      6:  byte_o = win_i.row_s[15:8];
      7:  byte_o = win_i.row_s[7:0];
      8:  byte_o = win_i.row_e[15:8];
      9:  byte_o = row_last[7:0];
      10: begin byte_o = CMD_MEM; dc_o = 1'b0; end
      default: byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/wws_beat_counter.sv
module wws_beat_counter #(
  parameter int CNT_W = 33
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/wws_top.sv
module wws_top
  import wws_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [COORD_W-1:0] req_x1_i,
  input  logic [COORD_W-1:0] req_x2_i,
  input  logic [COORD_W-1:0] req_y1_i,
  input  logic [COORD_W-1:0] req_y2_i,
  output logic               busy_o,
  input  logic               px_valid_i,
  input  logic [7:0]         px_data_i,
  output logic               px_ready_o,
  output logic               out_valid_o,
  output logic [7:0]         out_byte_o,
  output logic               out_dc_o,
  input  logic               out_ready_i,
  output logic               done_o
);
  localparam int CNT_W = 2 * COORD_W + 1;
  localparam int IDX_W = $clog2(HDR_LEN);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HDR_LEN - 1);

  state_e           state_q;
  logic [IDX_W-1:0] idx_q;
  win_t             win_q, win_d;
  logic             done_q;
  logic             empty_d, accept, data_fire, last_beat;
  logic [CNT_W-1:0] beats_d;
  logic [7:0]       hdr_byte;
  logic             hdr_dc;

  wws_window #(.COORD_W(COORD_W)) u_window (
    .x1_i   (req_x1_i),
    .x2_i   (req_x2_i),
    .y1_i   (req_y1_i),
    .y2_i   (req_y2_i),
    .win_o  (win_d),
    .empty_o(empty_d),
    .beats_o(beats_d)
  );

  wws_header u_header (
    .idx_i (idx_q),
    .win_i (win_q),
    .byte_o(hdr_byte),
    .dc_o  (hdr_dc)
  );

  assign accept    = (state_q == ST_IDLE) && req_valid_i;
  assign data_fire = (state_q == ST_DATA) && px_valid_i && out_ready_i;

  wws_beat_counter #(.CNT_W(CNT_W)) u_beats (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept && !empty_d),
    .load_val_i(beats_d),
    .dec_i     (data_fire),
    .last_o    (last_beat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      win_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          if (empty_d) begin
            done_q <= 1'b1;
          end else begin
            win_q   <= win_d;
            idx_q   <= '0;
            state_q <= ST_HDR;
          end
        end
        ST_HDR: if (out_ready_i) begin
          if (idx_q == IDX_LAST) state_q <= ST_DATA;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_DATA: if (data_fire && last_beat) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    out_valid_o = 1'b0;
    out_byte_o  = 8'h00;
    out_dc_o    = 1'b0;
    case (state_q)
      ST_HDR: begin
        out_valid_o = 1'b1;
        out_byte_o  = hdr_byte;
        out_dc_o    = hdr_dc;
      end
      ST_DATA: begin
        out_valid_o = px_valid_i;
        out_byte_o  = px_data_i;
        out_dc_o    = 1'b1;
      end
      default: ;
    endcase
  end

  assign px_ready_o = (state_q == ST_DATA) && out_ready_i;
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
endmodule

// File: rtl/wws_checker.sv
module wws_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       px_ready_o,
  input logic       out_valid_o,
  input logic [7:0] out_byte_o,
  input logic       out_dc_o,
  input logic       out_ready_i,
  input logic       done_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!out_valid_o && !px_ready_o));

  assert_px_ready_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_ready_o |-> (out_ready_i && out_dc_o && busy_o));

  assert_cmd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_dc_o && !out_ready_i)
      |=> (out_valid_o && !out_dc_o && $stable(out_byte_o)));

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind wws_top wws_checker u_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .px_ready_o (px_ready_o),
  .out_valid_o(out_valid_o),
  .out_byte_o (out_byte_o),
  .out_dc_o   (out_dc_o),
  .out_ready_i(out_ready_i),
  .done_o     (done_o)
);

// File: tb/wws_top_tb.sv
`timescale 1ns/1ps
module wws_top_tb_top;
  localparam int COORD_W = 16;
  localparam int NVEC = 7;
  // {x1, x2, y1, y2}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd0,   16'd6,   16'd0,   16'd2},
    {16'd4,   16'd8,   16'd1,   16'd4},
    {16'd5,   16'd7,   16'd300, 16'd302},
    {16'd765, 16'd770, 16'd0,   16'd1},
    {16'd3,   16'd3,   16'd0,   16'd5},
    {16'd0,   16'd3,   16'd4,   16'd4},
    {16'd0,   16'd1,   16'd0,   16'd1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [COORD_W-1:0] x1 = '0, x2 = '0, y1 = '0, y2 = '0;
  logic busy, px_valid = 1'b0, px_ready, out_valid, out_dc, out_ready = 1'b0, done;
  logic [7:0] px_data = '0, out_byte;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wws_top #(.COORD_W(COORD_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid),
    .req_x1_i(x1), .req_x2_i(x2), .req_y1_i(y1), .req_y2_i(y2),
    .busy_o(busy), .px_valid_i(px_valid), .px_data_i(px_data), .px_ready_o(px_ready),
    .out_valid_o(out_valid), .out_byte_o(out_byte), .out_dc_o(out_dc),
    .out_ready_i(out_ready), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // jam: hold a different request high while busy (R9)
  task automatic run_xfer(input int ax1, input int ax2, input int ay1, input int ay2, input bit jam);
    int s, e, cnt, n, px_cnt, last_cyc, base;
    bit empty, got_done;
    int hdr [11];
    bit hdc [11];
    s = ax1 / 3;
    e = (ax2 + 2) / 3;
    empty = (ax2 <= ax1) || (ay2 <= ay1);
    cnt = empty ? 0 : (e - s) * (ay2 - ay1);
    hdr = '{8'h2A, (s >> 8) & 255, s & 255, (e >> 8) & 255, (e - 1) & 255,
            8'h2B, (ay1 >> 8) & 255, ay1 & 255, (ay2 >> 8) & 255, (ay2 - 1) & 255, 8'h2C};
    hdc = '{0, 1, 1, 1, 1, 0, 1, 1, 1, 1, 0};
    base = (ax1 * 7 + ay2 * 13) & 255;
    n = 0; px_cnt = 0; last_cyc = -10; got_done = 0;
    @(negedge clk);
    req_valid = 1'b1;
    x1 = COORD_W'(ax1); x2 = COORD_W'(ax2); y1 = COORD_W'(ay1); y2 = COORD_W'(ay2);
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      if (jam) begin
        req_valid = 1'b1;
        x1 = 16'd0; x2 = 16'd30; y1 = 16'd0; y2 = 16'd9;
      end else begin
        req_valid = 1'b0;
      end
      out_ready = (cyc % 4) != 2;
      px_valid  = (cyc % 5) != 3;
      px_data   = 8'(base + px_cnt);
      #1;
      if (done) begin
        req_valid = 1'b0;
        got_done = 1;
        if (empty) begin
          check(cyc == 0, "R8 done cycle after empty request", cyc, 0);
          check(busy == 1'b0, "R8 busy stays low", busy, 0);
        end else begin
          check(cyc == last_cyc + 1, "R7 done right after last byte", cyc, last_cyc + 1);
        end
        check(n == 11 * (empty ? 0 : 1) + cnt, "R5 total byte count", n, 11 * (empty ? 0 : 1) + cnt);
        break;
      end
      if (out_valid && out_ready) begin
        if (n < 11) begin
          check(out_byte == 8'(hdr[n]), n < 5 ? "R2 column header byte" :
                (n < 10 ? "R3 row header byte" : "R4 memory write command"), out_byte, hdr[n]);
          check(out_dc == hdc[n], "R4 command/data select", out_dc, hdc[n]);
        end else begin
          check(out_byte == 8'(base + n - 11), "R5 data byte passthrough", out_byte, (base + n - 11) & 255);
          check(out_dc == 1'b1, "R4 data select high", out_dc, 1);
        end
        if (n >= 11 + cnt - 1) last_cyc = cyc;
        n++;
      end
      if (px_valid && px_ready) px_cnt++;
    end
    check(got_done, "R7 done seen", got_done, 1);
    @(negedge clk);
    #1;
    check(done == 1'b0, "R7 done is one cycle", done, 0);
    check(px_ready == 1'b0 && busy == 1'b0, "R5 no pixel read after transfer", px_ready, 0);
  endtask

  initial begin
    #3;
    #1;
    check(busy == 0 && out_valid == 0 && done == 0 && px_ready == 0, "R1 reset state", busy, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++)
      run_xfer(int'(VEC[i][63:48]), int'(VEC[i][47:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]), 1'b0);

    // R9: request held during a transfer changes nothing
    run_xfer(9, 12, 2, 3, 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(busy == 1'b0 && out_valid == 1'b0, "R9 jammed request not started", busy, 0);
    end

    // R6: stalled command byte is held
    @(negedge clk);
    out_ready = 1'b0;
    req_valid = 1'b1; x1 = 16'd0; x2 = 16'd3; y1 = 16'd0; y2 = 16'd1;
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    check(out_valid && out_byte == 8'h2A && !out_dc, "R6 first command offered", out_byte, 8'h2A);
    @(negedge clk);
    #1;
    check(out_valid && out_byte == 8'h2A && !out_dc, "R6 command held under stall", out_byte, 8'h2A);

    // R1: reset mid-transfer returns to idle
    rst_n = 1'b0;
    #1;
    check(busy == 0 && out_valid == 0 && done == 0, "R1 idle after reset mid-transfer", busy, 0);
    @(negedge clk);
    rst_n = 1'b1;
    out_ready = 1'b1;
    run_xfer(1, 2, 7, 8, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule